// File: doc/BRIEF.md
# Debug command framing sequencer

This block sits above the serial bit transceiver of a debug port and turns a stream of received fields into debug transactions. The first field of every frame is an 8-bit command. From that command the block decides whether a 16-bit address field follows, whether a 16-bit data field follows it, and whether the data flows from the host to the target or the other way.

Once the operands are complete, the block issues one access on a simple request/acknowledge memory port. It then holds a fixed bus-clock delay that gives the access time to finish. After a read, it offers the fetched word to the transceiver for return to the host. After a write, it keeps the next command off until the delay has run out. Commands that only run or step the processor carry no operands and are followed by a shorter fixed delay; this block handles them only as a delay stub. Opcodes of any other class are dropped.

A link timeout reported by the bit layer abandons any frame that is still collecting fields or returning data.

Top module: `dbg_frame_seq`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, and `mem_req_o`, `tx_valid_o` and `exp_wide_o` are 0.
- R2: The opcode is the low 8 bits of the command field. Bit 7 set means a hardware access, and for those bit 3 set means read and clear means write. Bit 7 clear with bit 6 set is a control command. Bits 7 and 6 both clear is unknown: the block stays in command wait (`cmd_ready_o` stays 1) and issues no access.
- R3: A read frame takes a command and then an address. When the address is accepted, one access with `mem_we_o`=0 at that address starts. `tx_valid_o` rises max(RD_DELAY, L) cycles after the address accept edge, where L is the number of cycles from that edge to the edge that samples `mem_ack_i`. `tx_data_o` then carries the acknowledged read word.
- R4: A write frame takes a command, then an address, then data. When the data is accepted, one access with `mem_we_o`=1 carrying that address and data starts. `cmd_ready_o` returns max(WR_DELAY, L) cycles after the data accept edge.
- R5: After a control command is accepted, `cmd_ready_o` stays low for exactly CTRL_DELAY cycles, and no access is issued.
- R6: `mem_req_o` stays high until the cycle in which `mem_ack_i` is sampled and is low in the next cycle. Each frame makes exactly one request, and no request is ever made while `cmd_ready_o` is high.
- R7: `link_timeout_i` asserted while an address or data field is awaited, or while read data is offered, returns the block to command wait in the next cycle. The abandoned frame issues no access.
- R8: `rx_valid_i` is ignored while an access or its delay is pending: the addresses, data and completion timing of that frame are unchanged.
- R9: `tx_valid_o` and `tx_data_o` hold until `tx_ready_i` is sampled high. `cmd_ready_o` is 1 in the next cycle.
- R10: `exp_wide_o` is 1 exactly while a 16-bit address or data field is awaited, and 0 in command wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rx_valid_i | input | 1 | a received field is presented |
| rx_data_i | input | 16 | received field, command in the low 8 bits |
| link_timeout_i | input | 1 | bit-layer timeout strobe |
| exp_wide_o | output | 1 | next field awaited is 16 bits wide |
| cmd_ready_o | output | 1 | waiting for a command field |
| tx_valid_o | output | 1 | read word offered for return |
| tx_data_o | output | 16 | read word to return |
| tx_ready_i | input | 1 | transceiver takes the read word |
| mem_req_o | output | 1 | memory access request |
| mem_we_o | output | 1 | access is a write |
| mem_addr_o | output | 16 | access address |
| mem_wdata_o | output | 16 | write data |
| mem_rdata_i | input | 16 | read data, valid with acknowledge |
| mem_ack_i | input | 1 | access acknowledge |

## Verification
The state flags move one cycle after the edge that accepts a field, a timeout or a transceiver take. The end of an access frame falls max(delay, L) cycles after its last operand edge, and the end of a control command falls exactly CTRL_DELAY cycles after its command edge. The bench drives inputs on falling edges and counts rising edges from the accepting edge. It samples outputs on the following falling edge and requires each flag to be low on every count before the expected one and high on that count. The memory model raises its acknowledge a chosen L cycles after the request, so that latencies below, at and above each delay are all swept.

// File: rtl/dbg_frame_pkg.sv
package dbg_frame_pkg;
  localparam int unsigned OP_W     = 8;
  localparam int unsigned HW_BIT   = 7;
  localparam int unsigned RD_BIT   = 3;
  localparam int unsigned CTRL_BIT = 6;

  typedef enum logic [1:0] {
    CLS_HW_RD = 2'd0,
    CLS_HW_WR = 2'd1,
    CLS_CTRL  = 2'd2,
    CLS_BAD   = 2'd3
  } cmd_cls_e;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WDATA = 3'd2,
    ST_ACC   = 3'd3,
    ST_WAIT  = 3'd4,
    ST_TX    = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_frame_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output cmd_cls_e        cls_o
);
  always_comb begin
    if (op_i[HW_BIT])        cls_o = op_i[RD_BIT] ? CLS_HW_RD : CLS_HW_WR;
    else if (op_i[CTRL_BIT]) cls_o = CLS_CTRL;
    else                     cls_o = CLS_BAD;
  end
endmodule

// File: rtl/dbg_delay_timer.sv
module dbg_delay_timer #(
  parameter int unsigned MAX_CNT = 150,
  localparam int unsigned CNT_W  = $clog2(MAX_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  // saturates at zero until reloaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o); // R5
  AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i))); // R5
endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
  import dbg_frame_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RD_DELAY   = 150,
  parameter int unsigned WR_DELAY   = 150,
  parameter int unsigned CTRL_DELAY = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              link_timeout_i,
  output logic              exp_wide_o,
  output logic              cmd_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int unsigned MAX_RW  = (RD_DELAY > WR_DELAY) ? RD_DELAY : WR_DELAY;
  localparam int unsigned MAX_DLY = (MAX_RW > CTRL_DELAY) ? MAX_RW : CTRL_DELAY;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_DELAY - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_DELAY - 1);
  localparam logic [CNT_W-1:0] CTRL_LOAD = CNT_W'(CTRL_DELAY - 1);

  seq_state_e        state_q, state_d;
  cmd_cls_e          dec_cls, cls_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              req_q, req_set;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              ack_seen;

  dbg_cmd_decode u_dec (
    .op_i  (rx_data_i[OP_W-1:0]),
    .cls_o (dec_cls)
  );

  dbg_delay_timer #(.MAX_CNT(MAX_DLY)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign ack_seen = req_q && mem_ack_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    req_set  = 1'b0;
    unique case (state_q)
      ST_CMD: if (rx_valid_i) begin
        unique case (dec_cls)
          CLS_HW_RD, CLS_HW_WR: state_d = ST_ADDR;
          CLS_CTRL: begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CTRL_LOAD;
          end
          default: state_d = ST_CMD;
        endcase
      end
      ST_ADDR: begin
        if (link_timeout_i) state_d = ST_CMD;
        else if (rx_valid_i) begin
          if (cls_q == CLS_HW_RD) begin
            state_d  = ST_ACC;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
            req_set  = 1'b1;
          end else begin
            state_d = ST_WDATA;
          end
        end
      end
      ST_WDATA: begin
        if (link_timeout_i) state_d = ST_CMD;
        else if (rx_valid_i) begin
          state_d  = ST_ACC;
          tmr_load = 1'b1;
          tmr_val  = WR_LOAD;
          req_set  = 1'b1;
        end
      end
      ST_ACC: if (ack_seen) begin
        if (!tmr_zero)              state_d = ST_WAIT;
        else if (cls_q == CLS_HW_RD) state_d = ST_TX;
        else                        state_d = ST_CMD;
      end
      ST_WAIT: if (tmr_zero) state_d = (cls_q == CLS_HW_RD) ? ST_TX : ST_CMD;
      ST_TX: if (link_timeout_i || tx_ready_i) state_d = ST_CMD;
      default: state_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cls_q   <= CLS_BAD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CMD && rx_valid_i) cls_q <= dec_cls;
      if (state_q == ST_ADDR && rx_valid_i && !link_timeout_i) addr_q <= rx_data_i[ADDR_W-1:0];
      if (state_q == ST_WDATA && rx_valid_i && !link_timeout_i) wdata_q <= rx_data_i;
      if (ack_seen) rdata_q <= mem_rdata_i;
      if (req_set)       req_q <= 1'b1;
      else if (ack_seen) req_q <= 1'b0;
    end
  end

  assign cmd_ready_o = (state_q == ST_CMD);
  assign exp_wide_o  = (state_q == ST_ADDR) || (state_q == ST_WDATA);
  assign tx_valid_o  = (state_q == ST_TX);
  assign tx_data_o   = rdata_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = (cls_q == CLS_HW_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o); // R6
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !mem_req_o); // R6
  AST_REQ_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && mem_req_o)); // R6
  AST_REQ_STABLE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o))); // R8
  AST_TIMEOUT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_timeout_i && (exp_wide_o || tx_valid_o)) |=> (cmd_ready_o && !mem_req_o)); // R7
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !link_timeout_i) |=> (tx_valid_o && $stable(tx_data_o))); // R9
  AST_TX_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |=> cmd_ready_o); // R9
  AST_UNKNOWN_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && rx_valid_i && !rx_data_i[7] && !rx_data_i[6]) |=> cmd_ready_o); // R2
  AST_WIDE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({exp_wide_o, cmd_ready_o, tx_valid_o})); // R10
endmodule

// File: tb/dbg_frame_seq_test.sv
`timescale 1ns/1ps
module dbg_frame_seq_test;
  localparam int RD_D = 150;
  localparam int WR_D = 150;
  localparam int CT_D = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_data = '0;
  logic        tmo = 1'b0;
  logic        exp_wide, cmd_ready, tx_valid, tx_ready = 1'b0;
  logic [15:0] tx_data;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int ack_cnt = 0;
  int req_count = 0;
  logic        cap_we;
  logic [15:0] cap_addr, cap_wdata;

  always #2 clk = ~clk;

  dbg_frame_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .link_timeout_i(tmo), .exp_wide_o(exp_wide), .cmd_ready_o(cmd_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // memory model: acknowledge sampled lat edges after request rises
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      ack_cnt = 0;
    end else if (mem_req) begin
      if (ack_cnt == 0) begin
        req_count++;
        cap_we = mem_we; cap_addr = mem_addr; cap_wdata = mem_wdata;
      end
      ack_cnt++;
      if (ack_cnt == lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem_addr ^ 16'h5a3c;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, accept edge follows, return at next negedge
  task automatic send(input logic [15:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0; rx_data = '0;
  endtask

  task automatic pulse_tmo();
    tmo = 1'b1;
    @(negedge clk);
    tmo = 1'b0;
  endtask

  // counts edges until flag rises; injects a stray field at k==2
  task automatic wait_flag(input bit use_tx, input int exp_k, input string req, input bit stray);
    int got = -1;
    for (int k = 1; k <= exp_k + 5; k++) begin
      if (stray && k == 2) begin rx_valid = 1'b1; rx_data = 16'hffff; end
      if (stray && k == 3) begin rx_valid = 1'b0; rx_data = '0; end
      @(negedge clk);
      if ((use_tx ? tx_valid : cmd_ready) && got < 0) got = k;
      if (got >= 0) break;
    end
    rx_valid = 1'b0;
    chk(got == exp_k, req, got, exp_k);
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    int lats[6] = '{1, 5, 149, 150, 151, 190};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(exp_wide == 1'b0, "R10 exp_wide idle", exp_wide, 0);

    // R2 unknown opcodes: stay in command wait, no access
    for (int op = 0; op < 64; op++) begin
      rc = req_count;
      send(16'hab00 | 16'(op));
      chk(cmd_ready && !exp_wide, "R2 unknown stays", op, 0);
      @(negedge clk);
      chk(!mem_req && req_count == rc, "R2 unknown no access", req_count, rc);
    end

    // R10/R7 every hardware opcode opens a wide field; timeout aborts it
    for (int op = 128; op < 256; op++) begin
      rc = req_count;
      send(16'(op));
      chk(exp_wide && !cmd_ready, "R10 wide after hw cmd", exp_wide, 1);
      pulse_tmo();
      chk(cmd_ready && !exp_wide, "R7 abort in addr", cmd_ready, 1);
      @(negedge clk);
      chk(req_count == rc && !mem_req, "R7 no access", req_count, rc);
    end

    // R5 control commands
    for (int op = 64; op < 128; op += 9) begin
      rc = req_count;
      send(16'(op));
      wait_flag(1'b0, CT_D, "R5 control delay", 1'b0);
      chk(req_count == rc, "R5 control no access", req_count, rc);
    end

    // R3 reads across latencies, stray field during delay (R8)
    foreach (lats[i]) begin
      lat = lats[i];
      rc = req_count;
      send(16'h0088);
      send(16'h1200 + 16'(i));
      wait_flag(1'b1, maxi(RD_D, lat), "R3 read timing", 1'b1);
      chk(req_count == rc + 1, "R6 one request", req_count, rc + 1);
      chk(!cap_we && cap_addr == 16'h1200 + 16'(i), "R3/R8 read addr", cap_addr, 16'h1200 + i);
      chk(tx_data == ((16'h1200 + 16'(i)) ^ 16'h5a3c), "R3 read data", tx_data, (16'h1200 + i) ^ 16'h5a3c);
      // R9 hold while not ready
      repeat (3) @(negedge clk);
      chk(tx_valid && tx_data == ((16'h1200 + 16'(i)) ^ 16'h5a3c), "R9 hold", tx_valid, 1);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      chk(cmd_ready && !tx_valid, "R9 done", cmd_ready, 1);
    end

    // R4 writes across latencies
    foreach (lats[i]) begin
      lat = lats[i];
      rc = req_count;
      send(16'h00f0);
      send(16'h4400 | 16'(i));
      chk(exp_wide, "R10 wide in data", exp_wide, 1);
      send(16'hc0de + 16'(i));
      wait_flag(1'b0, maxi(WR_D, lat), "R4 write timing", 1'b1);
      chk(req_count == rc + 1, "R6 one request", req_count, rc + 1);
      chk(cap_we && cap_addr == (16'h4400 | 16'(i)), "R4 write addr", cap_addr, 16'h4400 | i);
      chk(cap_wdata == 16'hc0de + 16'(i), "R4/R8 write data", cap_wdata, 16'hc0de + i);
    end

    // R7 timeout while awaiting write data
    lat = 1;
    rc = req_count;
    send(16'h0080);
    send(16'h7777);
    pulse_tmo();
    chk(cmd_ready, "R7 abort in data", cmd_ready, 1);
    repeat (3) @(negedge clk);
    chk(req_count == rc, "R7 data abort no access", req_count, rc);

    // R7 timeout while offering read data
    send(16'h0088);
    send(16'h0042);
    wait_flag(1'b1, RD_D, "R3 read timing", 1'b0);
    pulse_tmo();
    chk(cmd_ready && !tx_valid, "R7 abort in tx", cmd_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule